// File: doc/BRIEF.md
# Serial Port Power Management Controller

This block sits beside a UART-style serial port and decides when that port may stop its clocks. Software sees one 4-bit control/status register on a small synchronous register bus. The block watches the transmit and receive FIFO empty flags, the FIFO push and pop strobes, host accesses to the data path and the receive line. From these it keeps an inactivity timeout and derives an idle status. It drives three outputs into the port core: a whole-port soft reset, a reset for the transmitter, receiver and FIFOs, and a powerdown (clock-gate) enable.

There are two powerdown paths. Direct powerdown is forced by software and flushes the transmit/receive side. Automatic powerdown is enabled by software but only taken once the hardware is idle, and it ends when the host touches the data path or a start bit arrives. A software soft reset returns the port to its hard-reset state. It is stretched to a minimum length by a counter and also cancels direct powerdown.

Top module: `serpm_top`

## Requirements
- R1: Register fields: bit 3 = automatic powerdown enable, bit 2 = soft reset, bit 1 = idle status (read-only), bit 0 = direct powerdown. A read strobe `regRe` sampled at a clock edge makes `regRdata` show the register as it stood before that edge, from the following cycle on.
- R2: After the hard reset `rstN`, every register bit reads 0, and `portRst`, `trxRst` and `pwrDown` are 0.
- R3: The idle bit is 1 only when both FIFOs are empty and the inactivity timeout has expired. The timeout reloads to `TIMEOUT_LOAD` on a FIFO push or pop, a receive-line transition or a host data access, then counts down once every `PRESCALE` clocks and holds at zero.
- R4: `pwrDown` enters automatic powerdown only when bit 3 is 1 and the idle conditions hold. With bit 3 at 0, automatic powerdown never occurs.
- R5: A host data access or a falling edge on `rxd` ends automatic powerdown and reloads the timeout. Powerdown is then re-entered only after a fresh timeout.
- R6: Writing 1 to bit 0 asserts `pwrDown` and `trxRst` from the next cycle. Writing 0 to bit 0 releases both.
- R7: Entering or leaving direct powerdown does not change the idle bit.
- R8: While in automatic powerdown, the idle bit follows only the two FIFO empty flags. A FIFO push or pop does not end automatic powerdown.
- R9: Writing 1 to bit 2 asserts `portRst` for at least `RESET_HOLD` cycles, even if bit 2 is cleared on the next write, and for as long as bit 2 stays 1. During that time `trxRst` is 1 and `pwrDown` is 0. Afterwards bits 3, 1 and 0 read 0.
- R10: Writes to bit 1 are ignored; it always reflects the live idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hard reset, active low, asynchronous |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regWdata | input | 4 | Register write data |
| regRdata | output | 4 | Register read data (registered) |
| txEmpty | input | 1 | Transmit FIFO empty |
| rxEmpty | input | 1 | Receive FIFO empty |
| fifoPush | input | 1 | A FIFO push occurred this cycle |
| fifoPop | input | 1 | A FIFO pop occurred this cycle |
| hostAccess | input | 1 | Host accessed the port data path this cycle |
| rxd | input | 1 | Serial receive line, asynchronous |
| portRst | output | 1 | Stretched whole-port soft reset |
| trxRst | output | 1 | Transmitter/receiver/FIFO reset |
| pwrDown | output | 1 | Powerdown / clock-gate enable |

## Verification
The bench clears the soft-reset bit on the very next write and counts the cycles of `portRst`. A design that forwarded bit 2 directly would give a one-cycle reset. One that failed to clear the mode bits would leave direct powerdown active after the reset. The bench also pops a FIFO entry during automatic powerdown. A design that woke on any counter reload, or that kept requiring the expired timeout for the idle bit, would drop `pwrDown` or read idle 0 there. Direct powerdown is entered with idle at both 1 and 0, which catches an idle bit tied to the powerdown mode. A write of 1 to bit 1 while busy catches a writable status bit.

// File: rtl/serpm_pkg.sv
package serpm_pkg;

  localparam int REG_W      = 4;
  localparam int BIT_AUTO   = 3;
  localparam int BIT_SRST   = 2;
  localparam int BIT_IDLE   = 1;
  localparam int BIT_DIRECT = 0;

  // control -> datapath strobes
  typedef struct packed {
    logic portRst;
    logic autoPd;
  } ctlStrobes_t;

  // datapath -> control status
  typedef struct packed {
    logic idleCond;
    logic wake;
    logic idleBit;
  } dpStatus_t;

endpackage

// File: rtl/serpm_dp.sv
module serpm_dp
  import serpm_pkg::*;
#(
  parameter int TIMEOUT_LOAD = 1024,
  parameter int PRESCALE     = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  logic        txEmpty,
  input  logic        rxEmpty,
  input  logic        fifoPush,
  input  logic        fifoPop,
  input  logic        hostAccess,
  input  logic        rxd,
  output dpStatus_t   status
);

  localparam int TO_W = $clog2(TIMEOUT_LOAD + 1);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [TO_W-1:0] TO_RELOAD = TO_W'(TIMEOUT_LOAD);
  localparam logic [PS_W-1:0] PS_LAST   = PS_W'(PRESCALE - 1);

  // receive line synchronizer, idle level is high
  logic [SYNC_STAGES-1:0] rxSync;
  logic rxPrev;
  logic rxLine;
  logic rxEdge;
  logic rxFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync <= '1;
      rxPrev <= 1'b1;
    end else begin
      rxSync[0] <= rxd;
      for (int i = 1; i < SYNC_STAGES; i++) rxSync[i] <= rxSync[i-1];
      rxPrev <= rxLine;
    end
  end

  assign rxLine = rxSync[SYNC_STAGES-1];
  assign rxEdge = rxLine ^ rxPrev;
  assign rxFall = rxPrev & ~rxLine;

  // prescaled tick
  logic tick;
  if (PRESCALE > 1) begin : g_div
    logic [PS_W-1:0] psCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                psCnt <= '0;
      else if (strobes.portRst || psCnt == PS_LAST) psCnt <= '0;
      else                                      psCnt <= psCnt + PS_W'(1);
    end
    assign tick = (psCnt == PS_LAST);
  end else begin : g_nodiv
    assign tick = 1'b1;
  end

  // inactivity timeout
  logic [TO_W-1:0] toCnt;
  logic reloadEv;
  logic expired;

  assign reloadEv = fifoPush | fifoPop | rxEdge | hostAccess;
  assign expired  = (toCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          toCnt <= TO_RELOAD;
    else if (strobes.portRst || reloadEv) toCnt <= TO_RELOAD;
    else if (tick && !expired)          toCnt <= toCnt - TO_W'(1);
  end

  // idle status bit
  logic bothEmpty;
  logic idleQ;
  assign bothEmpty = txEmpty & rxEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               idleQ <= 1'b0;
    else if (strobes.portRst) idleQ <= 1'b0;
    else if (strobes.autoPd)  idleQ <= bothEmpty;
    else                     idleQ <= bothEmpty & expired;
  end

  assign status.idleCond = bothEmpty & expired;
  assign status.wake     = hostAccess | rxFall;
  assign status.idleBit  = idleQ;

endmodule

// File: rtl/serpm_ctrl.sv
module serpm_ctrl
  import serpm_pkg::*;
#(
  parameter int RESET_HOLD = 113000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regRe,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  dpStatus_t        status,
  output ctlStrobes_t      strobes,
  output logic             portRst,
  output logic             trxRst,
  output logic             pwrDown
);

  localparam int HOLD_W = $clog2(RESET_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(RESET_HOLD);

  logic              autoEn;
  logic              softBit;
  logic              directPd;
  logic              autoPd;
  logic [HOLD_W-1:0] holdCnt;
  logic              srstWrite;
  logic              rstActive;

  assign srstWrite = regWe & regWdata[BIT_SRST];
  assign rstActive = softBit | (holdCnt != '0);

  // soft reset bit and stretch counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softBit <= 1'b0;
      holdCnt <= '0;
    end else begin
      if (regWe) softBit <= regWdata[BIT_SRST];
      if (srstWrite)            holdCnt <= HOLD_LOAD;
      else if (holdCnt != '0)   holdCnt <= holdCnt - HOLD_W'(1);
    end
  end

  // mode bits: cleared by the soft reset, otherwise software owned
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoEn   <= 1'b0;
      directPd <= 1'b0;
    end else if (rstActive || srstWrite) begin
      autoEn   <= 1'b0;
      directPd <= 1'b0;
    end else if (regWe) begin
      autoEn   <= regWdata[BIT_AUTO];
      directPd <= regWdata[BIT_DIRECT];
    end
  end

  // automatic powerdown state; clearing wins over entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              autoPd <= 1'b0;
    else if (rstActive || !autoEn || status.wake) autoPd <= 1'b0;
    else if (status.idleCond)               autoPd <= 1'b1;
  end

  // registered read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdata <= '0;
    else if (regRe) begin
      regRdata[BIT_AUTO]   <= autoEn;
      regRdata[BIT_SRST]   <= softBit;
      regRdata[BIT_IDLE]   <= status.idleBit;
      regRdata[BIT_DIRECT] <= directPd;
    end
  end

  assign strobes.portRst = rstActive;
  assign strobes.autoPd  = autoPd;

  assign portRst = rstActive;
  assign trxRst  = directPd | rstActive;
  assign pwrDown = (directPd | autoPd) & ~rstActive;

endmodule

// File: rtl/serpm_top.sv
module serpm_top
  import serpm_pkg::*;
#(
  parameter int TIMEOUT_LOAD = 1024,
  parameter int PRESCALE     = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int RESET_HOLD   = 113000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regRe,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic             txEmpty,
  input  logic             rxEmpty,
  input  logic             fifoPush,
  input  logic             fifoPop,
  input  logic             hostAccess,
  input  logic             rxd,
  output logic             portRst,
  output logic             trxRst,
  output logic             pwrDown
);

  ctlStrobes_t strobes;
  dpStatus_t   status;

  serpm_ctrl #(
    .RESET_HOLD(RESET_HOLD)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regRe    (regRe),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .status   (status),
    .strobes  (strobes),
    .portRst  (portRst),
    .trxRst   (trxRst),
    .pwrDown  (pwrDown)
  );

  serpm_dp #(
    .TIMEOUT_LOAD(TIMEOUT_LOAD),
    .PRESCALE    (PRESCALE),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .txEmpty    (txEmpty),
    .rxEmpty    (rxEmpty),
    .fifoPush   (fifoPush),
    .fifoPop    (fifoPop),
    .hostAccess (hostAccess),
    .rxd        (rxd),
    .status     (status)
  );

endmodule

// File: rtl/serpm_chk.sv
module serpm_chk #(
  parameter int RESET_HOLD = 113000
) (
  input logic clk,
  input logic rstN,
  input logic regWe,
  input logic txEmpty,
  input logic rxEmpty,
  input logic hostAccess,
  input logic portRst,
  input logic trxRst,
  input logic pwrDown
);

  int hiCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        hiCnt <= 0;
    else if (portRst) hiCnt <= hiCnt + 1;
    else              hiCnt <= 0;
  end

  // R9
  reset_stretch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(portRst) |-> (hiCnt >= RESET_HOLD));

  // R9
  no_pd_in_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    portRst |-> !pwrDown);

  // R9
  trx_in_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    portRst |-> trxRst);

  // R4
  auto_needs_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pwrDown) && !trxRst) |-> $past(txEmpty && rxEmpty));

  // R5
  host_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostAccess && !regWe) |=> (!pwrDown || trxRst));

endmodule

bind serpm_top serpm_chk #(.RESET_HOLD(RESET_HOLD)) u_chk (.*);

// File: tb/serpm_top_tb.sv
module serpm_top_tb;

  localparam int TL   = 8;
  localparam int PS   = 4;
  localparam int HOLD = 20;

  logic       clk = 1'b0;
  logic       rstN;
  logic       regWe, regRe;
  logic [3:0] regWdata;
  logic [3:0] regRdata;
  logic       txEmpty, rxEmpty, fifoPush, fifoPop, hostAccess, rxd;
  logic       portRst, trxRst, pwrDown;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  serpm_top #(
    .TIMEOUT_LOAD(TL), .PRESCALE(PS), .SYNC_STAGES(2), .RESET_HOLD(HOLD)
  ) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
    .regWdata(regWdata), .regRdata(regRdata),
    .txEmpty(txEmpty), .rxEmpty(rxEmpty), .fifoPush(fifoPush),
    .fifoPop(fifoPop), .hostAccess(hostAccess), .rxd(rxd),
    .portRst(portRst), .trxRst(trxRst), .pwrDown(pwrDown)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge clk); regWe = 1'b1; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(output logic [3:0] d);
    @(negedge clk); regRe = 1'b1;
    @(negedge clk); regRe = 1'b0; d = regRdata;
  endtask

  task automatic pulseHost();
    @(negedge clk); hostAccess = 1'b1;
    @(negedge clk); hostAccess = 1'b0;
  endtask

  task automatic t_reset();
    logic [3:0] v;
    rd(v);
    check("R2 reg", v, 0);
    check("R2 portRst", portRst, 0);
    check("R2 trxRst", trxRst, 0);
    check("R2 pwrDown", pwrDown, 0);
  endtask

  task automatic t_idle();
    logic [3:0] v;
    pulseHost(); waitN(20); rd(v); check("R3 idle before expiry", v[1], 0);
    waitN(25); rd(v); check("R3 idle after expiry", v[1], 1);
    txEmpty = 1'b0; waitN(2); rd(v); check("R3 tx not empty", v[1], 0);
    txEmpty = 1'b1; waitN(2); rd(v); check("R3 tx empty again", v[1], 1);
    @(negedge clk); fifoPush = 1'b1; @(negedge clk); fifoPush = 1'b0;
    waitN(20); rd(v); check("R3 push reload", v[1], 0);
    waitN(25); rd(v); check("R3 push expiry", v[1], 1);
    rxd = 1'b0; waitN(3); rxd = 1'b1;
    waitN(20); rd(v); check("R3 rx edge reload", v[1], 0);
    waitN(25); rd(v); check("R3 rx expiry", v[1], 1);
  endtask

  task automatic t_autoOff();
    waitN(10);
    check("R4 disabled no pd", pwrDown, 0);
  endtask

  task automatic t_auto();
    logic [3:0] v;
    wr(4'b1000); waitN(3);
    check("R4 auto pd", pwrDown, 1);
    check("R4 no trx reset", trxRst, 0);
    rd(v); check("R1 readback", v, 4'b1010);
  endtask

  task automatic t_autoIdle();
    logic [3:0] v;
    @(negedge clk); fifoPop = 1'b1; @(negedge clk); fifoPop = 1'b0;
    waitN(3);
    check("R8 pop no wake", pwrDown, 1);
    rd(v); check("R8 idle empties only", v[1], 1);
    rxEmpty = 1'b0; waitN(2); rd(v);
    check("R8 idle rx not empty", v[1], 0);
    check("R8 still pd", pwrDown, 1);
    rxEmpty = 1'b1; waitN(2); rd(v);
    check("R8 idle rx empty", v[1], 1);
  endtask

  task automatic t_wake();
    pulseHost();
    check("R5 host wake", pwrDown, 0);
    waitN(45);
    check("R5 re-enter after host", pwrDown, 1);
    rxd = 1'b0; waitN(4);
    check("R5 start bit wake", pwrDown, 0);
    rxd = 1'b1; waitN(45);
    check("R5 re-enter after rx", pwrDown, 1);
  endtask

  task automatic t_direct();
    logic [3:0] v;
    wr(4'b0000); waitN(2);
    check("R4 auto disabled", pwrDown, 0);
    wr(4'b0001);
    check("R6 direct pd", pwrDown, 1);
    check("R6 direct trx", trxRst, 1);
    rd(v); check("R7 idle kept 1", v, 4'b0011);
    wr(4'b0000);
    check("R6 exit pd", pwrDown, 0);
    check("R6 exit trx", trxRst, 0);
    pulseHost(); waitN(2);
    wr(4'b0001);
    rd(v); check("R7 idle kept 0", v, 4'b0001);
    wr(4'b0000);
  endtask

  task automatic t_bit1();
    logic [3:0] v;
    wr(4'b0010);
    rd(v); check("R10 write 1 ignored", v, 4'b0000);
    waitN(40);
    rd(v); check("R10 idle live", v, 4'b0010);
    wr(4'b0000);
    rd(v); check("R10 write 0 ignored", v, 4'b0010);
  endtask

  task automatic t_softReset();
    logic [3:0] v;
    int n;
    wr(4'b1001);
    check("R6 direct before reset", pwrDown, 1);
    @(negedge clk); regWe = 1'b1; regWdata = 4'b0100;
    @(negedge clk);
    check("R9 pd low in reset", pwrDown, 0);
    check("R9 trx in reset", trxRst, 1);
    n = 0;
    while (portRst && n < 200) begin
      n++;
      if (n == 1) regWdata = 4'b0000;
      else regWe = 1'b0;
      @(negedge clk);
    end
    regWe = 1'b0;
    check("R9 stretch length", n, HOLD);
    check("R9 pd after reset", pwrDown, 0);
    rd(v); check("R9 regs cleared", v, 4'b0000);
    wr(4'b0100); waitN(HOLD + 10);
    check("R9 held reset", portRst, 1);
    wr(4'b0000);
    check("R9 release", portRst, 0);
  endtask

  initial begin
    rstN = 1'b0; regWe = 1'b0; regRe = 1'b0; regWdata = '0;
    txEmpty = 1'b1; rxEmpty = 1'b1; fifoPush = 1'b0; fifoPop = 1'b0;
    hostAccess = 1'b0; rxd = 1'b1;
    waitN(3);
    rstN = 1'b1;
    t_reset();
    t_idle();
    t_autoOff();
    t_auto();
    t_autoIdle();
    t_wake();
    t_direct();
    t_bit1();
    t_softReset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule